// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a handful of recent virtual-to-physical page translations and answers lookups without a trip to the page tables in memory. A 32-bit virtual address is split into a 20-bit virtual page number and a 12-bit byte offset within a 4 KB page. Every stored entry compares its tag against the incoming page number at once. On a match, the physical address is formed in the same cycle from the stored frame number and the unmodified offset. A writable flag kept with the entry is returned alongside.

After a miss, the surrounding logic finds the translation elsewhere and installs it through the fill port. If no entry is free, the least recently used one is replaced. One entry can be dropped by page number when its mapping or its protection changes. The whole table can be cleared in one cycle when the address space switches.

Top module: `tlb_cache`

## Requirements
- R1: After synchronous reset every entry is invalid, so any lookup misses.
- R2: A lookup whose page number matches a valid entry asserts `lk_hit` in the same cycle. `lk_paddr` is then the stored 20-bit frame number in bits 31:12 above the lookup's bits 11:0, and `lk_wr` is the stored writable bit.
- R3: When `lk_valid` is low or no valid entry matches, `lk_hit` and `lk_wr` are 0 and `lk_paddr` is zero.
- R4: A fill with `flush` low makes its translation visible to lookups from the next cycle on.
- R5: A fill whose page number is already stored overwrites that entry's frame number and writable bit and takes no further entry.
- R6: A fill of a new page number uses a free (invalid) entry whenever one exists, before evicting any valid entry.
- R7: When all entries are valid, a fill of a new page number replaces the least recently used entry. Both a lookup hit and a fill make their entry the most recently used.
- R8: An invalidate removes only the entry whose page number matches `inv_vpn`. An invalidate with no matching entry changes nothing.
- R9: A flush clears every valid bit, so all lookups in the following cycle miss.
- R10: A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_paddr | output | 32 | Translated physical address, zero on a miss |
| lk_wr | output | 1 | Writable bit of the matching entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_wr | input | 1 | Writable bit to install |
| inv_en | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| flush | input | 1 | Invalidate every entry |

## Verification
The hardest situations to reach are those where the replacement order matters: a full table in which the least recently used entry is not the oldest fill, and a table with one hole left by an invalidate while older valid entries remain. The stimulus first fills all eight entries, then uses lookup hits to reorder recency so the eviction target differs from the first-filled entry. It then invalidates a recently used entry so that a free-slot-first choice and a pure recency choice pick different victims. The bench then checks which page numbers survive. Overwrite without duplication is shown by a second fill of a stored page, after which a recent entry must still be present.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DEF_ADDR_W  = 32;
  localparam int DEF_PAGE_W  = 12;
  localparam int DEF_FRAME_W = 20;
  localparam int DEF_ENTRIES = 8;

  // which event refreshes the recency order this cycle
  typedef enum logic [1:0] {
    TS_NONE = 2'd0,
    TS_LOOK = 2'd1,
    TS_FILL = 2'd2
  } touch_src_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int TAG_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            hits,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  // one comparator per entry, all in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end

  assign any = |hits;

  // lowest matching index; at most one matches in normal operation
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     valid,
  output logic [IDX_W-1:0] victim
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [N-1:0][IDX_W-1:0] ages;
  logic [IDX_W-1:0]        oldest_idx;
  logic [IDX_W-1:0]        free_idx;
  logic                    any_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ages[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)
          ages[i] <= '0;
        else if (ages[i] < ages[touch_idx])
          ages[i] <= ages[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ages[i] == IDX_W'(N - 1)) oldest_idx = IDX_W'(i);
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid;
  assign victim   = any_free ? free_idx : oldest_idx;
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int PAGE_W  = DEF_PAGE_W,
  parameter int FRAME_W = DEF_FRAME_W,
  parameter int ENTRIES = DEF_ENTRIES,
  localparam int VPN_W  = ADDR_W - PAGE_W,
  localparam int PA_W   = FRAME_W + PAGE_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_vaddr,
  output logic               lk_hit,
  output logic [PA_W-1:0]    lk_paddr,
  output logic               lk_wr,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_pfn,
  input  logic               fill_wr,
  input  logic               inv_en,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               flush
);
  // entry storage
  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]   ent_tag;
  logic [ENTRIES-1:0][FRAME_W-1:0] ent_pfn;
  logic [ENTRIES-1:0]              ent_wr;

  // match results
  logic [ENTRIES-1:0] look_hits, fill_hits, inv_hits;
  logic               look_any, fill_any, inv_any;
  logic [IDX_W-1:0]   look_idx, fill_idx, inv_idx;

  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   fill_tgt;
  logic               fill_go;
  touch_src_e         touch_src;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_look (
    .valid (ent_valid),
    .tags  (ent_tag),
    .key   (lk_vaddr[ADDR_W-1:PAGE_W]),
    .hits  (look_hits),
    .any   (look_any),
    .idx   (look_idx)
  );

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill (
    .valid (ent_valid),
    .tags  (ent_tag),
    .key   (fill_vpn),
    .hits  (fill_hits),
    .any   (fill_any),
    .idx   (fill_idx)
  );

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_inv (
    .valid (ent_valid),
    .tags  (ent_tag),
    .key   (inv_vpn),
    .hits  (inv_hits),
    .any   (inv_any),
    .idx   (inv_idx)
  );

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .valid     (ent_valid),
    .victim    (victim_idx)
  );

  // flush wins over fill; an existing tag is rewritten in place
  assign fill_go  = fill_en && !flush;
  assign fill_tgt = fill_any ? fill_idx : victim_idx;

  always_comb begin
    if (fill_go)
      touch_src = TS_FILL;
    else if (lk_valid && look_any)
      touch_src = TS_LOOK;
    else
      touch_src = TS_NONE;
  end

  assign touch_en  = (touch_src != TS_NONE);
  assign touch_idx = (touch_src == TS_FILL) ? fill_tgt : look_idx;

  // valid bits: reset, flush, single invalidate, then fill
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ent_valid <= '0;
    end else begin
      if (inv_en && inv_any) ent_valid[inv_idx] <= 1'b0;
      if (fill_go) ent_valid[fill_tgt] <= 1'b1;
    end
  end

  // payload written without reset
  always_ff @(posedge clk) begin
    if (fill_go) begin
      ent_tag[fill_tgt] <= fill_vpn;
      ent_pfn[fill_tgt] <= fill_pfn;
      ent_wr[fill_tgt]  <= fill_wr;
    end
  end

  assign lk_hit   = lk_valid && look_any;
  assign lk_paddr = lk_hit ? {ent_pfn[look_idx], lk_vaddr[PAGE_W-1:0]} : '0;
  assign lk_wr    = lk_hit && ent_wr[look_idx];

  logic unused_ok;
  assign unused_ok = ^{fill_hits, inv_hits};
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 12,
  parameter int FRAME_W = 20,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = ADDR_W - PAGE_W,
  localparam int PA_W   = FRAME_W + PAGE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [ADDR_W-1:0]  lk_vaddr,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_paddr,
  input logic               lk_wr,
  input logic               fill_en,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic               inv_en,
  input logic [VPN_W-1:0]   inv_vpn,
  input logic               flush,
  input logic [ENTRIES-1:0] look_hits
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[PAGE_W-1:0] == lk_vaddr[PAGE_W-1:0]));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == '0 && !lk_wr));

  assert_fill_visible_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=>
      (!(lk_valid && lk_vaddr[ADDR_W-1:PAGE_W] == $past(fill_vpn)) || lk_hit));

  assert_single_copy_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_hits));

  assert_inv_gone_R8: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !(fill_en && fill_vpn == inv_vpn)) |=>
      (!(lk_valid && lk_vaddr[ADDR_W-1:PAGE_W] == $past(inv_vpn)) || !lk_hit));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);
endmodule

bind tlb_cache tlb_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_wr(lk_wr),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .inv_en(inv_en),
  .inv_vpn(inv_vpn), .flush(flush), .look_hits(look_hits)
);

// File: tb/tlb_cache_tb.sv
module tlb_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        lk_wr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_wr = 1'b0;
  logic        inv_en = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard queues
  bit          q_hit[$];
  logic [31:0] q_pa[$];
  bit          q_wr[$];
  string       q_req[$];

  always #10 clk = ~clk;

  tlb_cache u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_wr(lk_wr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wr(fill_wr), .inv_en(inv_en), .inv_vpn(inv_vpn), .flush(flush)
  );

  task automatic idle();
    lk_valid = 1'b0; fill_en = 1'b0; inv_en = 1'b0; flush = 1'b0;
  endtask

  // driver: one lookup cycle, expectation pushed for the monitor
  task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                      input bit eh, input logic [19:0] epfn, input bit ew,
                      input string req);
    @(negedge clk);
    idle();
    lk_valid = 1'b1;
    lk_vaddr = {vpn, off};
    q_hit.push_back(eh);
    q_pa.push_back(eh ? {epfn, off} : 32'h0);
    q_wr.push_back(eh ? ew : 1'b0);
    q_req.push_back(req);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input bit wr, input bit with_flush);
    @(negedge clk);
    idle();
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_wr = wr;
    flush = with_flush;
  endtask

  task automatic inval(input logic [19:0] vpn);
    @(negedge clk);
    idle();
    inv_en = 1'b1; inv_vpn = vpn;
  endtask

  task automatic do_flush();
    @(negedge clk);
    idle();
    flush = 1'b1;
  endtask

  // monitor: compares mid-cycle, well away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (lk_valid && q_hit.size() > 0) begin
        bit          eh;
        logic [31:0] ep;
        bit          ew;
        string       rq;
        eh = q_hit.pop_front();
        ep = q_pa.pop_front();
        ew = q_wr.pop_front();
        rq = q_req.pop_front();
        checks++;
        if (lk_hit !== eh || lk_paddr !== ep || lk_wr !== ew) begin
          errors++;
          $display("FAIL %s vaddr=%h: hit=%b pa=%h wr=%b expected hit=%b pa=%h wr=%b",
                   rq, lk_vaddr, lk_hit, lk_paddr, lk_wr, eh, ep, ew);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look(20'h00010, 12'h123, 1'b0, 20'h0, 1'b0, "R1");

    // R4/R2: fill all eight, then hit each
    for (int i = 0; i < 8; i++) fill(20'h10 + 20'(i), 20'hA0 + 20'(i), i[0], 1'b0);
    for (int i = 0; i < 8; i++)
      look(20'h10 + 20'(i), 12'hABC, 1'b1, 20'hA0 + 20'(i), i[0], "R2");

    // R7: hit on 0x10 shifts the victim to 0x11
    look(20'h10, 12'h001, 1'b1, 20'hA0, 1'b0, "R7");
    fill(20'h20, 20'hB0, 1'b1, 1'b0);
    look(20'h11, 12'h002, 1'b0, 20'h0, 1'b0, "R7");
    look(20'h10, 12'h003, 1'b1, 20'hA0, 1'b0, "R7");
    look(20'h20, 12'h004, 1'b1, 20'hB0, 1'b1, "R4");

    // R5: rewrite of a stored page, no slot consumed
    fill(20'h12, 20'h55, 1'b1, 1'b0);
    look(20'h12, 12'h777, 1'b1, 20'h55, 1'b1, "R5");
    look(20'h13, 12'h010, 1'b1, 20'hA3, 1'b1, "R5");
    fill(20'h21, 20'hB1, 1'b0, 1'b0);
    look(20'h14, 12'h011, 1'b0, 20'h0, 1'b0, "R7");
    look(20'h13, 12'h012, 1'b1, 20'hA3, 1'b1, "R7");

    // R8: single invalidate of a recent entry
    inval(20'h13);
    look(20'h13, 12'h020, 1'b0, 20'h0, 1'b0, "R8");
    look(20'h15, 12'h021, 1'b1, 20'hA5, 1'b1, "R8");

    // R6: the hole is used before the least recent entry (0x16)
    fill(20'h22, 20'hB2, 1'b0, 1'b0);
    look(20'h16, 12'h030, 1'b1, 20'hA6, 1'b0, "R6");
    look(20'h22, 12'h031, 1'b1, 20'hB2, 1'b0, "R6");

    // R8: invalidate of an absent page changes nothing
    inval(20'h99);
    look(20'h17, 12'h040, 1'b1, 20'hA7, 1'b1, "R8");
    look(20'h21, 12'h041, 1'b1, 20'hB1, 1'b0, "R8");

    // R9: flush
    do_flush();
    look(20'h10, 12'h050, 1'b0, 20'h0, 1'b0, "R9");
    look(20'h20, 12'h051, 1'b0, 20'h0, 1'b0, "R9");
    look(20'h22, 12'h052, 1'b0, 20'h0, 1'b0, "R9");

    // R4 after flush, then R10: flush beats a same-cycle fill
    fill(20'h40, 20'hC0, 1'b1, 1'b0);
    look(20'h40, 12'h060, 1'b1, 20'hC0, 1'b1, "R4");
    fill(20'h30, 20'hD0, 1'b1, 1'b1);
    look(20'h30, 12'h061, 1'b0, 20'h0, 1'b0, "R10");
    look(20'h40, 12'h062, 1'b0, 20'h0, 1'b0, "R10");

    // R3: stored page but no request -> outputs quiet
    fill(20'h41, 20'hC1, 1'b1, 1'b0);
    @(negedge clk);
    idle();
    lk_vaddr = {20'h41, 12'h070};
    #5;
    checks++;
    if (lk_hit !== 1'b0 || lk_paddr !== 32'h0 || lk_wr !== 1'b0) begin
      errors++;
      $display("FAIL R3 idle lookup: hit=%b pa=%h wr=%b expected hit=0 pa=00000000 wr=0",
               lk_hit, lk_paddr, lk_wr);
    end
    look(20'h41, 12'h071, 1'b1, 20'hC1, 1'b1, "R3");

    @(negedge clk);
    idle();
    #10;
    if (q_hit.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_hit.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule